// File: doc/BRIEF.md
# Serial Queue RAM Indirect Access Port

This block sits between a host register bus and the small RAM that holds the work queue of a serial transfer engine. The RAM has three regions. The transmit region holds 16-bit outgoing words. The receive region holds 16-bit incoming words. The command region holds 8-bit per-transfer commands. The host never addresses the RAM directly. It loads a 6-bit pointer register, then reads or writes a data register. Each data access touches the entry under the pointer and then moves the pointer on by one.

The transfer engine is outside this block. It supplies a busy flag and the index of the command entry it is executing. It reads transmit and command entries through its own read ports, and it stores received words through a separate write port. A host write that lands on the command entry the engine is running, while the engine is busy, is a collision. The block reports every collision with a one-clock pulse. When the access-error option is enabled, the block also refuses the write and returns an error flag.

Top module: `qram_port`

## Requirements
- R1: After reset the pointer is 0x00, every RAM entry is zero, and `coll_pulse` and `h_err` are low.
- R2: A host write with `h_sel`=0 loads `h_wdata[5:0]` into the pointer. With `h_sel`=0, `h_rdata` shows the pointer zero-extended to 16 bits.
- R3: Every host data access (`h_sel`=1 with `h_wr` or `h_rd`) advances the pointer by exactly one. Region boundaries do not stop it, so 0x0F goes to 0x10, 0x1F to 0x20 and 0x2F to 0x30. Past 0x3F it rolls over to 0x00.
- R4: Pointer values 0x00–0x0F select transmit entries, index `ptr[3:0]`. These entries are read and written as 16 bits. `eng_tx_data` shows the entry at `eng_tx_idx`.
- R5: Pointer values 0x10–0x1F select receive entries. The host can read them, but its writes there are dropped. `eng_rx_we` stores `eng_rx_data` at `eng_rx_idx`.
- R6: Pointer values 0x20–0x2F select command entries. Only `h_wdata[7:0]` is stored, and reads return the byte zero-extended. `eng_cmd_data` shows the entry at `eng_cmd_ptr`.
- R7: Pointer values 0x30–0x3F select no entry. Data reads there return zero and data writes there change nothing.
- R8: A host data write at pointer 0x20+`eng_cmd_ptr` while `eng_busy`=1 is a collision. `coll_pulse` goes high in the next cycle for exactly one cycle per colliding write. No other access raises it.
- R9: With `err_en`=0 a colliding write is still stored. With `err_en`=1 the write is blocked, and `h_err` is high in the same cycle as the write. The pointer advances in both cases. `h_err` is high only on such a blocked write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (advances the pointer on a data read) |
| h_sel | input | 1 | Register select: 0 = pointer register, 1 = data register |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data for the selected register (combinational) |
| h_err | output | 1 | Access error: a colliding write was blocked |
| err_en | input | 1 | Enables blocking of colliding writes |
| eng_busy | input | 1 | Engine is running a transfer |
| eng_cmd_ptr | input | 4 | Index of the command entry being executed |
| eng_cmd_data | output | 8 | Command entry at `eng_cmd_ptr` |
| eng_tx_idx | input | 4 | Transmit entry index the engine reads |
| eng_tx_data | output | 16 | Transmit entry at `eng_tx_idx` |
| eng_rx_we | input | 1 | Engine receive write strobe |
| eng_rx_idx | input | 4 | Receive entry index to write |
| eng_rx_data | input | 16 | Received word to store |
| coll_pulse | output | 1 | One-cycle write-collision event |

## Verification
The assertions assume the host never raises `h_wr` and `h_rd` in the same cycle. They also assume that pointer loads and data accesses do not overlap, because `h_sel` chooses exactly one register per access. The stimulus drives at most one strobe per cycle and holds the engine-side inputs stable across each clock edge. `eng_busy` and `eng_cmd_ptr` change only between host accesses, so a collision depends only on the values present at the write.

// File: rtl/qram_pkg.sv
package qram_pkg;
  localparam int PTR_W    = 6;
  localparam int IDX_W    = 4;
  localparam int REGION_N = 1 << IDX_W;

  typedef enum logic [1:0] {
    RG_TX   = 2'd0,
    RG_RX   = 2'd1,
    RG_CMD  = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  function automatic region_e region_of(input logic [PTR_W-1:0] p);
    return region_e'(p[PTR_W-1:IDX_W]);
  endfunction

  function automatic logic [IDX_W-1:0] index_of(input logic [PTR_W-1:0] p);
    return p[IDX_W-1:0];
  endfunction

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return p + {{(PTR_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/qram_ptr_reg.sv
module qram_ptr_reg
  import qram_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr_step(ptr);
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (ptr == PTR_W'($past(ptr) + 1))); // R3
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(ptr)); // R3
endmodule

// File: rtl/qram_bank.sv
module qram_bank #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ra_idx,
  output logic [W-1:0]  ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic [W-1:0]  rb_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
endmodule

// File: rtl/qram_coll_det.sv
module qram_coll_det
  import qram_pkg::*;
(
  input  logic             data_wr,
  input  logic [PTR_W-1:0] ptr,
  input  logic             busy,
  input  logic [IDX_W-1:0] live_idx,
  input  logic             err_en,
  output logic             hit,
  output logic             block
);
  assign hit   = data_wr && busy && (region_of(ptr) == RG_CMD) && (index_of(ptr) == live_idx);
  assign block = hit && err_en;
endmodule

// File: rtl/qram_port.sv
module qram_port
  import qram_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CMD_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                h_wr,
  input  logic                h_rd,
  input  logic                h_sel,
  input  logic [DATA_W-1:0]   h_wdata,
  output logic [DATA_W-1:0]   h_rdata,
  output logic                h_err,
  input  logic                err_en,
  input  logic                eng_busy,
  input  logic [IDX_W-1:0]    eng_cmd_ptr,
  output logic [CMD_W-1:0]    eng_cmd_data,
  input  logic [IDX_W-1:0]    eng_tx_idx,
  output logic [DATA_W-1:0]   eng_tx_data,
  input  logic                eng_rx_we,
  input  logic [IDX_W-1:0]    eng_rx_idx,
  input  logic [DATA_W-1:0]   eng_rx_data,
  output logic                coll_pulse
);
  logic [PTR_W-1:0]  ptr;
  logic              data_acc, data_wr, ptr_load;
  logic              coll_hit, coll_block;
  logic              tx_we, cmd_we;
  logic [IDX_W-1:0]  idx;
  region_e           rgn;
  logic [DATA_W-1:0] tx_rd, rx_rd, rx_unused;
  logic [CMD_W-1:0]  cmd_rd;
  logic [DATA_W-1:0] data_rd;

  assign data_acc = h_sel && (h_wr || h_rd);
  assign data_wr  = h_sel && h_wr;
  assign ptr_load = !h_sel && h_wr;
  assign rgn      = region_of(ptr);
  assign idx      = index_of(ptr);

  qram_ptr_reg u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(h_wdata[PTR_W-1:0]),
    .step(data_acc), .ptr(ptr)
  );

  qram_coll_det u_coll (
    .data_wr(data_wr), .ptr(ptr), .busy(eng_busy), .live_idx(eng_cmd_ptr),
    .err_en(err_en), .hit(coll_hit), .block(coll_block)
  );

  assign tx_we  = data_wr && (rgn == RG_TX);
  assign cmd_we = data_wr && (rgn == RG_CMD) && !coll_block;

  qram_bank #(.W(DATA_W), .DEPTH(REGION_N)) u_tx (
    .clk(clk), .rst_n(rst_n), .we(tx_we), .widx(idx), .wdata(h_wdata),
    .ra_idx(idx), .ra_data(tx_rd), .rb_idx(eng_tx_idx), .rb_data(eng_tx_data)
  );

  qram_bank #(.W(DATA_W), .DEPTH(REGION_N)) u_rx (
    .clk(clk), .rst_n(rst_n), .we(eng_rx_we), .widx(eng_rx_idx), .wdata(eng_rx_data),
    .ra_idx(idx), .ra_data(rx_rd), .rb_idx(idx), .rb_data(rx_unused)
  );

  qram_bank #(.W(CMD_W), .DEPTH(REGION_N)) u_cmd (
    .clk(clk), .rst_n(rst_n), .we(cmd_we), .widx(idx), .wdata(h_wdata[CMD_W-1:0]),
    .ra_idx(idx), .ra_data(cmd_rd), .rb_idx(eng_cmd_ptr), .rb_data(eng_cmd_data)
  );

  always_comb begin
    unique case (rgn)
      RG_TX:   data_rd = tx_rd;
      RG_RX:   data_rd = rx_rd;
      RG_CMD:  data_rd = {{(DATA_W-CMD_W){1'b0}}, cmd_rd};
      default: data_rd = '0;
    endcase
  end

  assign h_rdata = h_sel ? data_rd : {{(DATA_W-PTR_W){1'b0}}, ptr};
  assign h_err   = coll_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coll_pulse <= 1'b0;
    else        coll_pulse <= coll_hit;
  end

  AST_PULSE_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    coll_pulse |-> $past(data_wr && eng_busy)); // R8
  AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    h_err |-> (err_en && h_wr && h_sel)); // R9
  AST_BLOCKED_CMD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (h_err && !$isunknown(eng_cmd_ptr)) |=> (eng_cmd_ptr != $past(eng_cmd_ptr)) || $stable(eng_cmd_data)); // R9
  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (h_sel && rgn == RG_NONE) |-> (h_rdata == '0)); // R7
endmodule

// File: tb/test_qram_port.sv
`timescale 1ns/1ps
module test_qram_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_wr = 0, h_rd = 0, h_sel = 0;
  logic [15:0] h_wdata = '0;
  logic [15:0] h_rdata;
  logic        h_err, err_en = 0, eng_busy = 0;
  logic [3:0]  eng_cmd_ptr = '0, eng_tx_idx = '0, eng_rx_idx = '0;
  logic [7:0]  eng_cmd_data;
  logic [15:0] eng_tx_data, eng_rx_data = '0;
  logic        eng_rx_we = 0;
  logic        coll_pulse;

  always #4 clk = ~clk;

  qram_port i_qram_port (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_sel(h_sel),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_err(h_err), .err_en(err_en),
    .eng_busy(eng_busy), .eng_cmd_ptr(eng_cmd_ptr), .eng_cmd_data(eng_cmd_data),
    .eng_tx_idx(eng_tx_idx), .eng_tx_data(eng_tx_data), .eng_rx_we(eng_rx_we),
    .eng_rx_idx(eng_rx_idx), .eng_rx_data(eng_rx_data), .coll_pulse(coll_pulse)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  string phase = "R1";

  int m_tx [16];
  int m_rx [16];
  int m_cmd[16];
  int m_ptr = 0;
  int m_pend = 0;

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int m_read();
    int i = m_ptr % 16;
    if (!h_sel) return m_ptr;
    if (m_ptr < 16) return m_tx[i];
    if (m_ptr < 32) return m_rx[i];
    if (m_ptr < 48) return m_cmd[i];
    return 0;
  endfunction

  // One host cycle: drive after the falling edge, check combinational outputs,
  // advance the model at the rising edge, check the registered pulse at the next fall.
  task automatic cyc(input bit wr, input bit rd, input bit sel, input int wd);
    bit hit;
    h_wr = wr; h_rd = rd; h_sel = sel; h_wdata = wd[15:0];
    #1;
    hit = wr && sel && eng_busy && (m_ptr >= 32) && (m_ptr < 48) && ((m_ptr % 16) == eng_cmd_ptr);
    chk(phase, h_rdata, m_read(), "h_rdata");
    chk("R9", h_err, hit && err_en, "h_err");
    chk("R4", eng_tx_data, m_tx[eng_tx_idx], "eng_tx_data");
    chk("R6", eng_cmd_data, m_cmd[eng_cmd_ptr], "eng_cmd_data");
    @(posedge clk);
    if (eng_rx_we) m_rx[eng_rx_idx] = eng_rx_data;
    if (wr && !sel) m_ptr = wd % 64;
    else if (sel && (wr || rd)) begin
      if (wr && m_ptr < 16) m_tx[m_ptr % 16] = wd & 16'hFFFF;
      if (wr && m_ptr >= 32 && m_ptr < 48 && !(hit && err_en)) m_cmd[m_ptr % 16] = wd & 8'hFF;
      m_ptr = (m_ptr + 1) % 64;
    end
    m_pend = hit;
    @(negedge clk);
    chk("R8", coll_pulse, m_pend, "coll_pulse");
  endtask

  task automatic set_ptr(input int p); cyc(1, 0, 0, p); endtask
  task automatic wr_data(input int d); cyc(1, 0, 1, d); endtask
  task automatic rd_data(); cyc(0, 1, 1, 0); endtask
  task automatic idle(input bit sel); cyc(0, 0, sel, 0); endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_tx[i] = 0; m_rx[i] = 0; m_cmd[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state seen at the ports
    chk("R1", h_rdata, 0, "pointer after reset");
    chk("R1", coll_pulse, 0, "coll_pulse after reset");
    chk("R1", h_err, 0, "h_err after reset");
    chk("R1", eng_tx_data, 0, "tx entry after reset");
    idle(1);

    phase = "R2"; set_ptr(6'h0E); idle(0);
    chk("R2", h_rdata, 16'h000E, "pointer readback");
    set_ptr(16'hFFC5); idle(0);               // upper bits ignored
    phase = "R4"; set_ptr(6'h0E);
    wr_data(16'hA5A5); wr_data(16'h1234);
    phase = "R3"; idle(0);
    chk("R3", h_rdata, 16'h0010, "0x0F steps to 0x10");
    phase = "R5"; wr_data(16'hFFFF);          // dropped, pointer 0x11
    eng_rx_we = 1; eng_rx_idx = 4'h0; eng_rx_data = 16'hBEEF; idle(1);
    eng_rx_idx = 4'h1; eng_rx_data = 16'h5A5A; idle(1);
    eng_rx_we = 0;
    set_ptr(6'h10); rd_data(); rd_data();
    phase = "R4"; set_ptr(6'h0E); rd_data(); rd_data();
    eng_tx_idx = 4'hF; idle(1);
    chk("R4", eng_tx_data, 16'h1234, "engine tx read");
    phase = "R3"; set_ptr(6'h1F); rd_data(); idle(0);
    chk("R3", h_rdata, 16'h0020, "0x1F steps to 0x20");
    phase = "R6"; wr_data(16'h01FF); wr_data(16'h0033);
    set_ptr(6'h20); rd_data(); rd_data();
    eng_cmd_ptr = 4'h1; idle(1);
    chk("R6", eng_cmd_data, 8'h33, "engine cmd read");
    phase = "R3"; set_ptr(6'h2F); wr_data(16'h0077); idle(0);
    chk("R3", h_rdata, 16'h0030, "0x2F steps to 0x30");
    phase = "R7"; wr_data(16'hDEAD); set_ptr(6'h30); rd_data(); rd_data();
    set_ptr(6'h3F); rd_data(); idle(0);
    chk("R3", h_rdata, 16'h0000, "0x3F rolls to 0x00");
    set_ptr(6'h0E); rd_data();

    phase = "R8"; eng_busy = 1; eng_cmd_ptr = 4'h3;
    set_ptr(6'h23); wr_data(16'h0011);        // collision, stored
    set_ptr(6'h22); wr_data(16'h0022);        // other entry, no collision
    set_ptr(6'h23); rd_data();                 // read never collides
    set_ptr(6'h03); wr_data(16'h0044);         // tx index 3, no collision
    phase = "R9"; err_en = 1;
    set_ptr(6'h23); wr_data(16'h0099);         // blocked
    idle(0);
    chk("R9", h_rdata, 16'h0024, "pointer advances on blocked write");
    set_ptr(6'h23); rd_data();
    chk("R9", m_cmd[3], 16'h0011, "model keeps blocked entry");
    phase = "R8"; eng_busy = 0;
    set_ptr(6'h23); wr_data(16'h0055);         // not busy, stored
    eng_busy = 1;
    set_ptr(6'h23); wr_data(16'h0066); wr_data(16'h0012);
    err_en = 0; eng_busy = 0;
    set_ptr(6'h23); rd_data(); rd_data();
    idle(1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule